// File: doc/BRIEF.md
# Extraction Word-Stream Decoder

This block sits between a switch queue system and a CPU-side frame buffer. It takes in the 32-bit words of one extracted frame at a time. Each frame starts with a fixed-length header, which is thrown away. After the header the block watches for in-band control words of the form 0x8000000X. These words mark the end of the frame, a pruned frame, an aborted frame, an escaped literal, or an idle filler. Payload words go out on a valid/ready stream unchanged. The block keeps a running byte count. When the frame ends it gives a one-cycle report with the byte total and a flag that says whether the frame must be discarded.

The output is a pass-through with no storage. A word accepted on the input that carries payload leaves on the output in the same cycle. Words that are dropped (header, idle filler, control codes, the word after an abort) are accepted whatever the output side is doing. An input selects byte-reversed comparison, for queue systems that present words in the other byte order. This reversal applies only to the comparison. The payload is never changed.

The decoder is built around six states:
- `ST_HEADER` counts header words.
- `ST_BODY` classifies each word.
- `ST_ESC_LIT` takes the literal after an escape.
- `ST_PRUNE_LIT` takes the last word of a pruned frame.
- `ST_EOF_TAIL` takes the final word of a good frame.
- `ST_ABORT_TAIL` swallows the word after an abort.

The transitions are:

| Transition | From | To |
|---|---|---|
| hdr_done | `ST_HEADER` | `ST_BODY` |
| esc_seen | `ST_BODY` | `ST_ESC_LIT` |
| lit_taken | `ST_ESC_LIT` | `ST_BODY` |
| prune_seen | `ST_BODY` | `ST_PRUNE_LIT` |
| eof_seen | `ST_BODY` | `ST_EOF_TAIL` |
| abort_seen | `ST_BODY` | `ST_ABORT_TAIL` |
| frame_end | any of the three end states | `ST_HEADER` |

Top module: `xtr_word_decoder`

## Requirements
- R1: The first HDR_WORDS accepted words of each frame (default 4, at least 1) are dropped and never decoded. This holds even if a header word equals a control code. No header word appears on the output.
- R2: Outside the header, a word that is not a control code is output unchanged and adds 4 to the frame byte count. A control code is a compared word whose bits 31:3 equal 0x10000000.
- R3: The not-ready code 0x80000007 is dropped. It has no effect on count, output or state.
- R4: The escape code 0x80000006 is dropped. The next word is then output as literal payload, even if it equals a control code, and adds 4 bytes. Decoding then resumes.
- R5: An end-of-frame code 0x80000000 to 0x80000003 adds 4 minus its low two bits (taken from the compared word) to the count. The next word is output as the final payload word, and the frame is reported good.
- R6: The pruned code 0x80000004 is followed by one word. That word is output and adds 4 bytes, and the frame is reported as discard.
- R7: The abort code 0x80000005 is followed by one word, which is dropped. The frame is reported as discard, with a count of the payload bytes before the abort.
- R8: When swap_en is 1, each word is byte-reversed (bits 7:0 become 31:24) before it is compared against the codes. Output words are always the received words, unchanged.
- R9: In the cycle after the frame's last word is accepted, done is high for exactly one cycle. At the same time done_bytes holds the frame's byte count and done_discard holds the discard flag. The next accepted word is header word 0 of a new frame.
- R10: A word bound for the output is accepted only when out_ready is 1 (in_ready follows out_ready). A word that is dropped is accepted with in_ready at 1 regardless of out_ready.
- R11: While rst_n is low and after its release, done and out_valid are low and the decoder expects header word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | Compare words byte-reversed against the codes |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | WORD_W | Input word |
| out_valid | output | 1 | Payload word valid |
| out_ready | input | 1 | Downstream can take the payload word |
| out_data | output | WORD_W | Payload word |
| done | output | 1 | One-cycle frame-end report |
| done_bytes | output | CNT_W | Byte count of the ended frame |
| done_discard | output | 1 | Ended frame was pruned or aborted |

## Verification
The hardest case to reach combines three conditions: a literal that carries a control-code value, reached after an escape, while the downstream is stalled. The decoder must hold the word without taking it as a code, and must not advance until out_ready returns. The stimulus reaches this case in three ways:
- It escapes words equal to end-of-frame and not-ready codes.
- It fills header positions with abort codes.
- It runs a late frame with out_ready driven by a pseudo-random pattern, so stalls land on escape literals and final words.

A frame with swap_en high sends a raw word that looks like a code in the unswapped order. The output must carry it as payload.

// File: rtl/xtr_pkg.sv
package xtr_pkg;

    typedef enum logic [2:0] {
        ST_HEADER,
        ST_BODY,
        ST_ESC_LIT,
        ST_PRUNE_LIT,
        ST_EOF_TAIL,
        ST_ABORT_TAIL
    } dec_state_e;

    typedef enum logic [2:0] {
        K_DATA,
        K_EOF,
        K_PRUNE,
        K_ABORT,
        K_ESC,
        K_IDLE
    } word_kind_e;

    localparam logic [28:0] CODE_PREFIX = 29'h1000_0000;

    function automatic word_kind_e kind_of(input logic [31:0] cmp);
        word_kind_e k;
        if (cmp[31:3] != CODE_PREFIX) begin
            k = K_DATA;
        end else begin
            unique case (cmp[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: k = K_EOF;
                3'd4:                   k = K_PRUNE;
                3'd5:                   k = K_ABORT;
                3'd6:                   k = K_ESC;
                default:                k = K_IDLE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/xtr_word_classify.sv
module xtr_word_classify
    import xtr_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] word,
    input  logic              swap_en,
    output word_kind_e        kind,
    output logic [1:0]        eof_low
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] cmp;

    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign swapped[8*b +: 8] = word[WORD_W-8-8*b +: 8];
    end

    assign cmp     = swap_en ? swapped : word;
    assign kind    = kind_of(cmp[31:0]);
    assign eof_low = cmp[1:0];

endmodule

// File: rtl/xtr_hdr_count.sv
module xtr_hdr_count #(
    parameter int HDR_WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic last
);
    localparam int HC_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam logic [HC_W-1:0] LAST_IDX = HC_W'(HDR_WORDS - 1);

    logic [HC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
        end
    end

    assign last = (cnt_q == LAST_IDX);

    // Header position never leaves its range.
    assert_hdr_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST_IDX);

endmodule

// File: rtl/xtr_byte_acc.sv
module xtr_byte_acc #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_en,
    input  logic [2:0]       add_val,
    input  logic             finish,
    output logic [CNT_W-1:0] total
);
    logic [CNT_W-1:0] acc_q;
    logic [CNT_W-1:0] sum;

    assign sum = acc_q + (add_en ? CNT_W'(add_val) : '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            total <= '0;
        end else if (finish) begin
            acc_q <= '0;
            total <= sum;
        end else begin
            acc_q <= sum;
        end
    end

endmodule

// File: rtl/xtr_word_decoder.sv
module xtr_word_decoder
    import xtr_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int HDR_WORDS = 4,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              done,
    output logic [CNT_W-1:0]  done_bytes,
    output logic              done_discard
);
    dec_state_e state_q, state_d;
    word_kind_e kind;
    logic [1:0] eof_low;
    logic       hdr_last;
    logic       accept;
    logic       emit;
    logic       add_en;
    logic [2:0] add_val;
    logic       frame_end;
    logic       end_discard;
    logic       done_q;
    logic       discard_q;

    xtr_word_classify #(.WORD_W(WORD_W)) u_classify (
        .word    (in_data),
        .swap_en (swap_en),
        .kind    (kind),
        .eof_low (eof_low)
    );

    xtr_hdr_count #(.HDR_WORDS(HDR_WORDS)) u_hdr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept && (state_q == ST_HEADER)),
        .last  (hdr_last)
    );

    xtr_byte_acc #(.CNT_W(CNT_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .add_en  (accept && add_en),
        .add_val (add_val),
        .finish  (accept && frame_end),
        .total   (done_bytes)
    );

    assign accept    = in_valid && in_ready;
    assign in_ready  = emit ? out_ready : 1'b1;
    assign out_valid = in_valid && emit;
    assign out_data  = in_data;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HEADER;
        end else if (accept) begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HEADER: begin
                if (hdr_last) state_d = ST_BODY;                    // hdr_done
            end
            ST_BODY: begin
                unique case (kind)
                    K_ESC:   state_d = ST_ESC_LIT;                  // esc_seen
                    K_PRUNE: state_d = ST_PRUNE_LIT;                // prune_seen
                    K_EOF:   state_d = ST_EOF_TAIL;                 // eof_seen
                    K_ABORT: state_d = ST_ABORT_TAIL;               // abort_seen
                    default: state_d = ST_BODY;
                endcase
            end
            ST_ESC_LIT:    state_d = ST_BODY;                       // lit_taken
            ST_PRUNE_LIT,
            ST_EOF_TAIL,
            ST_ABORT_TAIL: state_d = ST_HEADER;                     // frame_end
            default:       state_d = ST_HEADER;
        endcase
    end

    // Per-word actions.
    always_comb begin
        emit        = 1'b0;
        add_en      = 1'b0;
        add_val     = 3'd4;
        frame_end   = 1'b0;
        end_discard = 1'b0;
        unique case (state_q)
            ST_HEADER: ;
            ST_BODY: begin
                if (kind == K_DATA) begin
                    emit   = 1'b1;
                    add_en = 1'b1;
                end else if (kind == K_EOF) begin
                    add_en  = 1'b1;
                    add_val = 3'd4 - {1'b0, eof_low};
                end
            end
            ST_ESC_LIT: begin
                emit   = 1'b1;
                add_en = 1'b1;
            end
            ST_PRUNE_LIT: begin
                emit        = 1'b1;
                add_en      = 1'b1;
                frame_end   = 1'b1;
                end_discard = 1'b1;
            end
            ST_EOF_TAIL: begin
                emit      = 1'b1;
                frame_end = 1'b1;
            end
            ST_ABORT_TAIL: begin
                frame_end   = 1'b1;
                end_discard = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            discard_q <= 1'b0;
        end else begin
            done_q    <= accept && frame_end;
            discard_q <= accept && frame_end && end_discard;
        end
    end

    assign done         = done_q;
    assign done_discard = discard_q;

    assert_hdr_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEADER) |-> !out_valid);

    assert_abort_tail_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ABORT_TAIL) |-> !out_valid);

    assert_done_follows_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(in_valid && in_ready));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_restarts_header_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_HEADER));

    assert_good_frame_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_discard) |-> (done_bytes != '0));

    assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/tb_xtr_word_decoder.sv
module tb_xtr_word_decoder;
    localparam int W   = 32;
    localparam int HDR = 4;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          swap_en = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [W-1:0]  in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [W-1:0]  out_data;
    logic          done;
    logic [CW-1:0] done_bytes;
    logic          done_discard;

    int checks = 0;
    int fails  = 0;
    logic bp_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic prev_done = 1'b0;
    int exp_bytes = 0;

    logic [W-1:0]  exp_w[$];
    logic [CW:0]   exp_d[$];

    always #5 clk = ~clk;

    xtr_word_decoder #(.WORD_W(W), .HDR_WORDS(HDR), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .swap_en(swap_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .done_bytes(done_bytes), .done_discard(done_discard)
    );

    task automatic chk(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] code(input int k);
        logic [W-1:0] c;
        c = 32'h8000_0000 | W'(k);
        return swap_en ? {c[7:0], c[15:8], c[23:16], c[31:24]} : c;
    endfunction

    // Driver
    task automatic push(input logic [W-1:0] w);
        in_data  = w;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // R1: header filled with abort codes, which must not be decoded
    task automatic t_hdr();
        exp_bytes = 0;
        for (int i = 0; i < HDR; i++) push(32'h8000_0005);
    endtask
    task automatic t_data(input logic [W-1:0] w);
        exp_w.push_back(w); exp_bytes += 4; push(w);
    endtask
    task automatic t_idle();  // R3
        push(code(7));
    endtask
    task automatic t_esc(input logic [W-1:0] lit);  // R4
        push(code(6)); exp_w.push_back(lit); exp_bytes += 4; push(lit);
    endtask
    task automatic t_eof(input int k, input logic [W-1:0] last);  // R5
        exp_bytes += 4 - k;
        exp_d.push_back({1'b0, CW'(exp_bytes)});
        push(code(k)); exp_w.push_back(last); push(last);
    endtask
    task automatic t_prune(input logic [W-1:0] lit);  // R6
        exp_bytes += 4;
        exp_d.push_back({1'b1, CW'(exp_bytes)});
        push(code(4)); exp_w.push_back(lit); push(lit);
    endtask
    task automatic t_abort(input logic [W-1:0] junk);  // R7
        exp_d.push_back({1'b1, CW'(exp_bytes)});
        push(code(5)); push(junk);
    endtask

    // Backpressure pattern
    initial forever begin
        @(posedge clk); #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_on ? lfsr[0] : 1'b1;
    end

    // Monitor / scoreboard
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (exp_w.size() == 0) chk(0, "R2 unexpected output", {1'b0, out_data}, '0);
                else begin
                    logic [W-1:0] e;
                    e = exp_w.pop_front();
                    chk(out_data == e, "R2/R4/R5/R6/R8 output word", {1'b0, out_data}, {1'b0, e});
                end
            end
            if (out_valid && !out_ready)
                chk(!in_ready, "R10 stalled word accepted", {{W{1'b0}}, in_ready}, '0);
            if (in_valid && !out_valid)
                chk(in_ready, "R10 dropped word not accepted", {{W{1'b0}}, in_ready}, 1);
            if (done) begin
                chk(!prev_done, "R9 done longer than one cycle", {{W{1'b0}}, prev_done}, '0);
                if (exp_d.size() == 0) chk(0, "R9 unexpected done", {16'h0, done_discard, done_bytes}, '0);
                else begin
                    logic [CW:0] d;
                    d = exp_d.pop_front();
                    chk({done_discard, done_bytes} == d, "R5/R6/R7/R9 frame report",
                        {16'h0, done_discard, done_bytes}, {16'h0, d});
                end
            end
            prev_done = done;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        chk(!done && !out_valid, "R11 reset outputs", {{(W-1){1'b0}}, done, out_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !out_valid, "R11 after release", {{(W-1){1'b0}}, done, out_valid}, '0);
        @(posedge clk); #1;

        // Frame 1: plain payload, EOF with all 4 bytes
        t_hdr(); t_data(32'h1111_2222); t_data(32'h3333_4444); t_eof(0, 32'hDEAD_BEEF);
        // Frame 2: idle filler, escaped code-valued literal, EOF with 1 byte
        t_hdr(); t_data(32'hA5A5_0001); t_idle(); t_data(32'hA5A5_0002);
        t_esc(32'h8000_0003); t_esc(32'h8000_0007); t_eof(3, 32'h0000_00AB);
        // Frame 3: pruned
        t_hdr(); t_data(32'h0BAD_F00D); t_prune(32'h8000_0000);
        // Frame 4: aborted
        t_hdr(); t_data(32'h0000_0010); t_data(32'h0000_0020); t_abort(32'h5555_5555);
        // Frame 5: byte-swapped comparison (R8)
        swap_en = 1'b1;
        t_hdr(); t_data(32'h8000_0001); t_idle(); t_esc(code(0)); t_eof(2, 32'h8000_0005);
        swap_en = 1'b0;
        // Frame 6: random backpressure (R10)
        bp_on = 1'b1;
        t_hdr();
        for (int i = 0; i < 12; i++) t_data(32'hC000_0000 + W'(i));
        t_esc(32'h8000_0006); t_idle(); t_esc(32'h8000_0004); t_eof(1, 32'hFEED_0001);
        t_hdr(); t_data(32'h7777_0000); t_prune(32'h7777_0001);
        bp_on = 1'b0;

        repeat (5) @(posedge clk);
        #1;
        chk(exp_w.size() == 0, "R2 output words missing", W'(exp_w.size()), '0);
        chk(exp_d.size() == 0, "R9 reports missing", W'(exp_d.size()), '0);
        finish_run();
    end

endmodule